// File: doc/BRIEF.md
# Peripheral Module Disable Controller

This block is the clock-control register front end of a bus-attached peripheral. Software writes a disable-request bit in the control register. The controller then waits until the peripheral's slave interface reports no outstanding transactions, and only then enters the disabled state. The real state is reported in a read-only status bit of the same register and on a functional-enable output that gates the peripheral's work.

While the module is disabled, the register port stays readable. A write to any register other than the control register is refused with a one-cycle bus error, and the target register keeps its value. Event logging stops. The log shows no write at all, not even the control-register write that brings the module back. Clearing the request bit either abandons a disable that is still draining or leaves the disabled state on the next clock. The block has no fractional divider and no sleep or suspend fields.

Top module: `pmd_ctrl_top`

## Requirements
- R1: After reset the control register (address 0) reads 0, `func_en` is 1, and no data register holds anything but 0.
- R2: Control register layout: bit 0 is the request bit (read/write), bit 1 is the status bit (read-only, 1 = disabled), and bits 31:2 read 0. Writes to bit 1 and to bits 31:2 have no effect.
- R3: A control write with bit 0 = 1 in a cycle where `txn_busy` is 0 makes the status bit 1 and `func_en` 0 from the next cycle on.
- R4: The status bit never becomes 1 in the cycle after a cycle where `txn_busy` was 1. A request made while busy takes effect in the cycle after the first cycle with `txn_busy` low.
- R5: While disabled, a write to a data register (addresses 1..NUM_REGS-1) raises `bus_err` in that same cycle only, and the register keeps its value.
- R6: Reads never raise `bus_err`, and while disabled they still return the current register contents.
- R7: While disabled, `log_valid` stays 0 for every write, including the control write that clears the request bit.
- R8: A control write with bit 0 = 0 while disabled makes the status bit 0 in the next cycle, and data writes are accepted from that cycle on.
- R9: A control write with bit 0 = 0 while a request is still waiting for `txn_busy` to fall cancels the disable, and the status bit stays 0.
- R10: While enabled, a write to an address below NUM_REGS pulses `log_valid` in the write's own cycle with `log_addr` equal to the address, and a write to a data register updates it. An address at or above NUM_REGS reads 0, is neither stored nor logged, and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe; each access completes in its own cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address, 0 = control register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid during a read access, 0 otherwise |
| bus_err | output | 1 | Rejected-write error, in the access's cycle |
| txn_busy | input | 1 | Peripheral slave interface has outstanding transactions |
| func_en | output | 1 | Functional enable of the peripheral (0 while disabled) |
| log_valid | output | 1 | Logging strobe for an accepted write |
| log_addr | output | ADDR_W | Address of the logged write |

## Verification
The hardest situation to reach is a request that is still draining and is then withdrawn. It needs `txn_busy` held high across the request write and across the later clearing write, followed by a fall of `txn_busy`. The bench drives this case directly with a long busy window. Its random phase keeps `txn_busy` high about half the time and writes the control register often with a random bit 0, so request, cancel and re-enable collide with busy edges and with rejected data writes in many orders.

// File: rtl/pmd_pkg.sv
package pmd_pkg;

  typedef enum logic [1:0] {
    PMD_RUN   = 2'd0,
    PMD_DRAIN = 2'd1,
    PMD_OFF   = 2'd2
  } pmd_state_e;

  // Next state from the request value that will hold after this cycle
  // and from the current busy indication.
  function automatic pmd_state_e pmd_next_state(input pmd_state_e cur,
                                                input logic req_nxt,
                                                input logic busy);
    pmd_state_e nxt;
    nxt = cur;
    unique case (cur)
      PMD_RUN:   if (req_nxt) nxt = busy ? PMD_DRAIN : PMD_OFF;
      PMD_DRAIN: if (!req_nxt) nxt = PMD_RUN;
                 else if (!busy) nxt = PMD_OFF;
      PMD_OFF:   if (!req_nxt) nxt = PMD_RUN;
      default:   nxt = PMD_RUN;
    endcase
    return nxt;
  endfunction

  function automatic logic pmd_is_off(input pmd_state_e s);
    return s == PMD_OFF;
  endfunction

endpackage

// File: rtl/pmd_decode.sv
module pmd_decode #(
  parameter int ADDR_W   = 4,
  parameter int NUM_REGS = 4
) (
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic              disabled,
  output logic              ctrl_wr,
  output logic              data_wr,
  output logic              rd_ctrl,
  output logic              rd_data,
  output logic              wr_reject,
  output logic              log_fire
);
  localparam logic [ADDR_W:0] REG_LIMIT = (ADDR_W+1)'(NUM_REGS);

  logic in_map;
  logic is_ctrl;
  logic is_data;

  always_comb begin
    in_map  = ({1'b0, addr} < REG_LIMIT);
    is_ctrl = (addr == '0);
    is_data = in_map && !is_ctrl;
  end

  always_comb begin
    ctrl_wr   = sel && we && is_ctrl;
    data_wr   = sel && we && is_data && !disabled;
    wr_reject = sel && we && is_data && disabled;
    rd_ctrl   = sel && !we && is_ctrl;
    rd_data   = sel && !we && is_data;
    log_fire  = sel && we && in_map && !disabled;
  end

endmodule

// File: rtl/pmd_fsm.sv
module pmd_fsm
  import pmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr,
  input  logic       req_wbit,
  input  logic       busy,
  output logic       req_q,
  output logic       disabled,
  output pmd_state_e state
);
  logic       req_nxt;
  pmd_state_e state_nxt;

  always_comb begin
    req_nxt   = ctrl_wr ? req_wbit : req_q;
    state_nxt = pmd_next_state(state, req_nxt, busy);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      state <= PMD_RUN;
    end else begin
      req_q <= req_nxt;
      state <= state_nxt;
    end
  end

  assign disabled = pmd_is_off(state);

endmodule

// File: rtl/pmd_regbank.sv
module pmd_regbank #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4,
  parameter int NUM_REGS = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          rdata,
  output logic [NUM_REGS*DATA_W-1:0] bank_flat
);
  assign bank_flat[DATA_W-1:0] = '0;

  for (genvar g = 1; g < NUM_REGS; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    logic              hit;
    assign hit = wr_en && (addr == ADDR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (hit) q <= wdata;
    end
    assign bank_flat[g*DATA_W +: DATA_W] = q;
  end

  always_comb begin
    rdata = '0;
    for (int i = 1; i < NUM_REGS; i++) begin
      if (addr == ADDR_W'(i)) rdata = bank_flat[i*DATA_W +: DATA_W];
    end
  end

endmodule

// File: rtl/pmd_ctrl_top.sv
module pmd_ctrl_top
  import pmd_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4,
  parameter int NUM_REGS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  input  logic              txn_busy,
  output logic              func_en,
  output logic              log_valid,
  output logic [ADDR_W-1:0] log_addr
);
  localparam int REQ_BIT  = 0;
  localparam int STAT_BIT = 1;

  logic ctrl_wr, data_wr, rd_ctrl, rd_data, wr_reject, log_fire;
  logic req_q, disabled;
  pmd_state_e state;
  logic [DATA_W-1:0] bank_rdata;
  logic [NUM_REGS*DATA_W-1:0] bank_flat;
  logic [DATA_W-1:0] ctrl_word;

  pmd_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dec (
    .sel(bus_sel), .we(bus_we), .addr(bus_addr), .disabled(disabled),
    .ctrl_wr(ctrl_wr), .data_wr(data_wr), .rd_ctrl(rd_ctrl),
    .rd_data(rd_data), .wr_reject(wr_reject), .log_fire(log_fire)
  );

  pmd_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr),
    .req_wbit(bus_wdata[REQ_BIT]), .busy(txn_busy),
    .req_q(req_q), .disabled(disabled), .state(state)
  );

  pmd_regbank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(data_wr), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bank_rdata), .bank_flat(bank_flat)
  );

  always_comb begin
    ctrl_word           = '0;
    ctrl_word[REQ_BIT]  = req_q;
    ctrl_word[STAT_BIT] = disabled;
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_ctrl)      bus_rdata = ctrl_word;
    else if (rd_data) bus_rdata = bank_rdata;
  end

  assign bus_err   = wr_reject;
  assign func_en   = !disabled;
  assign log_valid = log_fire;
  assign log_addr  = log_fire ? bus_addr : '0;

endmodule

// File: rtl/pmd_ctrl_chk.sv
module pmd_ctrl_chk #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4,
  parameter int NUM_REGS = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       bus_sel,
  input logic                       bus_we,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic [DATA_W-1:0]          bus_wdata,
  input logic                       bus_err,
  input logic                       txn_busy,
  input logic                       func_en,
  input logic                       log_valid,
  input logic                       disabled,
  input logic [NUM_REGS*DATA_W-1:0] bank_flat
);
  // R4
  drain_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disabled) |-> !$past(txn_busy));

  // R5
  reject_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> $stable(bank_flat));

  // R5
  err_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_sel && bus_we && !func_en));

  // R6
  read_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we) |-> !bus_err);

  // R7
  off_no_log_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !func_en |-> !log_valid);

  // R8
  clear_leaves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == '0 && !bus_wdata[0]) |=> func_en);

  // R3
  enable_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    func_en == !disabled);

endmodule

bind pmd_ctrl_top pmd_ctrl_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_err(bus_err),
  .txn_busy(txn_busy), .func_en(func_en), .log_valid(log_valid),
  .disabled(disabled), .bank_flat(bank_flat)
);

// File: tb/test_pmd_ctrl_top.sv
module test_pmd_ctrl_top;
  localparam int DW = 32;
  localparam int AW = 4;
  localparam int NR = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, we = 1'b0, busy = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic err, fen, lv;
  logic [AW-1:0] la;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // model state
  logic m_req = 1'b0;
  logic m_off = 1'b0;
  logic [DW-1:0] m_reg [NR];

  always #10 clk = ~clk;

  pmd_ctrl_top #(.DATA_W(DW), .ADDR_W(AW), .NUM_REGS(NR)) i_pmd_ctrl_top (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .bus_err(err), .txn_busy(busy),
    .func_en(fen), .log_valid(lv), .log_addr(la)
  );

  function automatic logic in_map(input logic [AW-1:0] a);
    return int'(a) < NR;
  endfunction

  function automatic logic [DW-1:0] exp_rdata(input logic s, input logic w,
                                              input logic [AW-1:0] a);
    if (!s || w || !in_map(a)) return '0;
    if (a == 0) return {{(DW-2){1'b0}}, m_off, m_req};
    return m_reg[a];
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input logic s, input logic w, input logic [AW-1:0] a,
                     input logic [DW-1:0] d, input logic b, input string tag);
    logic e_err, e_lv, nreq;
    @(negedge clk);
    sel = s; we = w; addr = a; wdata = d; busy = b;
    #5;
    e_err = s && w && a != 0 && in_map(a) && m_off;
    e_lv  = s && w && in_map(a) && !m_off;
    chk(tag, "rdata (R2/R6)", rdata, exp_rdata(s, w, a));
    chk(tag, "bus_err (R5)", DW'(err), DW'(e_err));
    chk(tag, "log_valid (R7/R10)", DW'(lv), DW'(e_lv));
    chk(tag, "func_en (R3/R4)", DW'(fen), DW'(!m_off));
    if (e_lv) chk(tag, "log_addr (R10)", DW'(la), DW'(a));
    @(posedge clk);
    #1;
    nreq = (s && w && a == 0) ? d[0] : m_req;
    if (s && w && a != 0 && in_map(a) && !m_off) m_reg[a] = d;
    m_off = m_off ? nreq : (nreq && !b);
    m_req = nreq;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic b, input string tag);
    cyc(1'b1, 1'b0, a, '0, b, tag);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                    input logic b, input string tag);
    cyc(1'b1, 1'b1, a, d, b, tag);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NR; i++) m_reg[i] = '0;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;

    // R1 reset state
    rd(0, 0, "R1");
    for (int i = 1; i < NR; i++) rd(AW'(i), 0, "R1");

    // R10 enabled writes, logging, out-of-map address
    wr(1, 32'hA5A5_0001, 0, "R10");
    wr(2, 32'h1234_5678, 0, "R10");
    wr(3, 32'hDEAD_BEEF, 0, "R10");
    wr(7, 32'hFFFF_FFFF, 0, "R10");
    rd(7, 0, "R10");
    rd(2, 0, "R10");

    // R2 reserved and status bits ignore writes
    wr(0, 32'hFFFF_FFFE, 0, "R2");
    rd(0, 0, "R2");

    // R4 request while busy waits for drain
    wr(0, 32'h1, 1, "R4");
    rd(0, 1, "R4");
    rd(0, 1, "R4");
    rd(0, 0, "R4");
    rd(0, 0, "R4");

    // R5 rejected write, R6 read while disabled
    wr(1, 32'h0BAD_0BAD, 0, "R5");
    rd(1, 0, "R6");
    rd(3, 0, "R6");

    // R7 control writes while disabled are not logged
    wr(0, 32'h1, 0, "R7");
    wr(0, 32'h0, 0, "R7");
    // R8 data write legal in the next cycle
    wr(2, 32'h0000_0042, 0, "R8");
    rd(2, 0, "R8");

    // R9 cancel while draining
    wr(0, 32'h1, 1, "R9");
    rd(0, 1, "R9");
    wr(0, 32'h0, 1, "R9");
    rd(0, 0, "R9");
    rd(0, 0, "R9");
    wr(3, 32'h0000_0099, 0, "R9");

    // R3 immediate disable when idle
    wr(0, 32'h1, 0, "R3");
    rd(0, 0, "R3");
    wr(0, 32'h0, 1, "R8");
    rd(0, 1, "R8");

    // mixed random traffic
    for (int n = 0; n < 600; n++) begin
      logic s, w, b;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      s = ($urandom % 10) < 7;
      w = $urandom % 2;
      a = AW'($urandom % 6);
      d = $urandom;
      b = ($urandom % 2);
      cyc(s, w, a, d, b, "R5");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule